// File: doc/BRIEF.md
# Hot-Plug Slot Command Tracker

This block holds the slot control and slot status registers of a hot-plug downstream port. It decides whether each configuration write to slot control is a hot-plug command. Each command passes the new indicator, power and interlock control values to a slot-pin controller over a valid/acknowledge handshake. When the controller acknowledges, the block sets a sticky Command Completed flag in slot status. Software clears that flag by writing one to it.

A mode input selects between two rules. In conforming mode, every write to slot control on a hot-plug-capable port is a command. In change-detect mode, a write is a command only when it alters one of the four command-bearing control fields. Writes that touch only the notification-enable bits are then never commands, so they never complete. A port that is not hot-plug capable stores written values but never issues a command.

Top module: `hp_slot_cmd_tracker`

## Requirements
- R1: After reset, slot_ctrl reads 0x0000, slot_sts reads 0x0000 and cmd_valid is low.
- R2: A write to offset 0xA8 stores all 16 data bits in slot_ctrl, visible the cycle after the write. A write to any address other than 0xA8 leaves slot_ctrl unchanged and starts no command.
- R3: In change-detect mode (conform_mode low), a slot control write is a command only when bits [11:6] of the written value differ from bits [11:6] of the stored value.
- R4: In change-detect mode with slot_ctrl at 0x0000, writing 0x1038 raises no command, and Command Completed stays clear.
- R5: In conforming mode (conform_mode high), every slot control write is a command, including one that repeats the stored value.
- R6: While hp_capable is low, no slot control write starts a command, in either mode. The written value is still stored.
- R7: A command drives cmd_valid high in the cycle after the write, with cmd_data equal to bits [11:6] of the written value. cmd_valid stays high and cmd_data stays stable until a cycle with cmd_ack high.
- R8: Command Completed (slot_sts bit 4) rises in the cycle after a cycle with cmd_valid and cmd_ack both high, and at no other time.
- R9: A write to offset 0xAA with data bit 4 set clears Command Completed. With bit 4 at zero, the write leaves it unchanged. The other data bits of that write are ignored.
- R10: If a delivery completes in the same cycle as a clearing write to 0xAA, Command Completed ends set.
- R11: A command issued while another is in flight is held. In the cycle after the in-flight command is acknowledged, it is presented on cmd_data with cmd_valid still high. If several commands arrive during one flight, only the latest is held.
- R12: The change comparison always uses the most recently written slot control value, even when that value's command has not yet been delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hp_capable | input | 1 | Port supports hot-plug; low suppresses all commands |
| conform_mode | input | 1 | 1: every write is a command; 0: only field changes count |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte offset of the write |
| cfg_wdata | input | 16 | Configuration write data |
| slot_ctrl | output | 16 | Current slot control register value |
| slot_sts | output | 16 | Slot status register; bit 4 is Command Completed |
| cmd_valid | output | 1 | Command presented to the slot-pin controller |
| cmd_data | output | 6 | Control bits [11:6] of the command |
| cmd_ack | input | 1 | Slot-pin controller accepts the presented command |

## Verification
The command decision shows up at cmd_valid one cycle after the write. A wrong stored value or mode decode therefore appears as a spurious or missing command on the next cycle. A delivery state that loses or reorders a held command shows up on cmd_data in the cycle after the acknowledge. A Command Completed flag that is set early or not cleared is visible on slot_sts bit 4 one cycle after the acknowledge or after the status write. The directed sequences probe each of these windows. They include the enable-only write, the overlapping commands, and the acknowledge that coincides with a status clear.

// File: rtl/hp_slot_pkg.sv
// Package: register offsets, field positions and shared types for the
// hot-plug slot command tracker. Assumes 16-bit slot registers.
package hp_slot_pkg;
    localparam int unsigned REG_W      = 16;
    localparam int unsigned FLD_LO     = 6;   // lowest command-bearing bit
    localparam int unsigned FLD_HI     = 11;  // highest command-bearing bit
    localparam int unsigned FLD_W      = FLD_HI - FLD_LO + 1;
    localparam int unsigned CC_BIT     = 4;   // Command Completed position

    typedef logic [REG_W-1:0] reg_word_t;
    typedef logic [FLD_W-1:0] cmd_fld_t;

    typedef enum logic [1:0] {
        DLV_IDLE = 2'b00,
        DLV_BUSY = 2'b01,
        DLV_HELD = 2'b10
    } dlv_state_t;
endpackage

// File: rtl/hp_cmd_detect.sv
// Module: hp_cmd_detect
// Decides whether a slot control write is a hot-plug command.
// Assumes old_val is the register value before this write.
module hp_cmd_detect
    import hp_slot_pkg::*;
(
    input  logic      ctrl_wr,
    input  logic      hp_capable,
    input  logic      conform_mode,
    input  reg_word_t old_val,
    input  reg_word_t new_val,
    output logic      issue,
    output cmd_fld_t  issue_fld
);
    cmd_fld_t old_fld;
    cmd_fld_t new_fld;
    logic     fld_changed;

    // Extract the command-bearing fields of both values.
    always_comb begin
        old_fld = old_val[FLD_HI:FLD_LO];
        new_fld = new_val[FLD_HI:FLD_LO];
    end

    // Compare fields and apply mode and capability gating.
    always_comb begin
        fld_changed = (old_fld != new_fld);
        issue       = ctrl_wr && hp_capable && (conform_mode || fld_changed);
        issue_fld   = new_fld;
    end

    // Notification-enable bits are outside the compared range.
    logic unused_bits;
    always_comb unused_bits = ^{old_val[REG_W-1:FLD_HI+1], old_val[FLD_LO-1:0],
                                new_val[REG_W-1:FLD_HI+1], new_val[FLD_LO-1:0]};
endmodule

// File: rtl/hp_cmd_deliver.sv
// Module: hp_cmd_deliver
// Presents commands to the slot-pin controller over valid/ack and keeps
// one held slot for a command that arrives while another is in flight.
// The latest arrival replaces a held one. Assumes cmd_ack is meaningful
// only while cmd_valid is high.
module hp_cmd_deliver
    import hp_slot_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     issue,
    input  cmd_fld_t issue_fld,
    input  logic     cmd_ack,
    output logic     cmd_valid,
    output cmd_fld_t cmd_data,
    output logic     done
);
    dlv_state_t state_q;
    cmd_fld_t   held_q;

    // One delivery finishes when the presented command is accepted.
    always_comb done = cmd_valid && cmd_ack;
    always_comb cmd_valid = (state_q != DLV_IDLE);

    // Delivery state, presented fields and held fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= DLV_IDLE;
            cmd_data <= '0;
            held_q   <= '0;
        end else begin
            unique case (state_q)
                DLV_IDLE: begin
                    if (issue) begin
                        state_q  <= DLV_BUSY;
                        cmd_data <= issue_fld;
                    end
                end
                DLV_BUSY: begin
                    if (done) begin
                        if (issue) cmd_data <= issue_fld;
                        else       state_q  <= DLV_IDLE;
                    end else if (issue) begin
                        held_q  <= issue_fld;
                        state_q <= DLV_HELD;
                    end
                end
                DLV_HELD: begin
                    if (done) begin
                        cmd_data <= issue ? issue_fld : held_q;
                        state_q  <= DLV_BUSY;
                    end else if (issue) begin
                        held_q <= issue_fld;
                    end
                end
                default: state_q <= DLV_IDLE;
            endcase
        end
    end

    // R7
    // valid_hold_chk: an unacknowledged command stays presented unchanged.
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_data)));

    // R11
    // held_follows_chk: a held command keeps cmd_valid high after the ack.
    held_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DLV_HELD && cmd_ack) |=> cmd_valid);
endmodule

// File: rtl/hp_sts_reg.sv
// Module: hp_sts_reg
// Sticky Command Completed flag: set by a finished delivery, cleared by a
// write-one to its bit. Set wins over a clear in the same cycle.
module hp_sts_reg
    import hp_slot_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      done,
    input  logic      clr,
    output reg_word_t sts
);
    logic cc_q;

    // Update the Command Completed flag.
    always_ff @(posedge clk) begin
        if (!rst_n)    cc_q <= 1'b0;
        else if (done) cc_q <= 1'b1;
        else if (clr)  cc_q <= 1'b0;
    end

    // Place the flag at its register position; other bits read zero.
    always_comb begin
        sts         = '0;
        sts[CC_BIT] = cc_q;
    end

    // R8
    // cc_after_ack_chk: the flag rises only after a finished delivery.
    cc_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_q) |-> $past(done));

    // R10
    // set_wins_chk: a delivery and a clear together leave the flag set.
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && clr) |=> cc_q);

    // R9
    // cc_clear_chk: a lone clear drops the flag.
    cc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !done) |=> !cc_q);
endmodule

// File: rtl/hp_slot_cmd_tracker.sv
// Module: hp_slot_cmd_tracker (top)
// Slot control / slot status registers of a hot-plug downstream port.
// Decodes configuration writes, decides which slot control writes are
// commands, delivers them and tracks Command Completed.
// Assumes one configuration write per cycle at most.
module hp_slot_cmd_tracker
    import hp_slot_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter logic [11:0] CTRL_OFS = 12'hA8,
    parameter logic [11:0] STS_OFS  = 12'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hp_capable,
    input  logic              conform_mode,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       slot_ctrl,
    output logic [15:0]       slot_sts,
    output logic              cmd_valid,
    output logic [5:0]        cmd_data,
    input  logic              cmd_ack
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] STS_A  = ADDR_W'(STS_OFS);

    logic      ctrl_wr;
    logic      sts_wr;
    logic      sts_clr;
    logic      issue;
    cmd_fld_t  issue_fld;
    logic      done;
    reg_word_t ctrl_q;

    // Decode which register the write targets.
    always_comb begin
        ctrl_wr = cfg_wr && (cfg_addr == CTRL_A);
        sts_wr  = cfg_wr && (cfg_addr == STS_A);
        sts_clr = sts_wr && cfg_wdata[CC_BIT];
    end

    // Store slot control immediately on each write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= cfg_wdata;
    end

    always_comb slot_ctrl = ctrl_q;

    hp_cmd_detect u_detect (
        .ctrl_wr      (ctrl_wr),
        .hp_capable   (hp_capable),
        .conform_mode (conform_mode),
        .old_val      (ctrl_q),
        .new_val      (cfg_wdata),
        .issue        (issue),
        .issue_fld    (issue_fld)
    );

    hp_cmd_deliver u_deliver (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .issue_fld (issue_fld),
        .cmd_ack   (cmd_ack),
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data),
        .done      (done)
    );

    hp_sts_reg u_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (done),
        .clr   (sts_clr),
        .sts   (slot_sts)
    );

    // R6
    // no_cmd_incapable_chk: an idle port that is not capable stays idle.
    no_cmd_incapable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hp_capable && !cmd_valid) |=> !cmd_valid);

    // R3
    // same_fields_idle_chk: in change-detect mode, an unchanged-field write
    // on an idle port raises nothing.
    same_fields_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !conform_mode && !cmd_valid &&
         cfg_wdata[FLD_HI:FLD_LO] == slot_ctrl[FLD_HI:FLD_LO]) |=> !cmd_valid);

    // R2
    // ctrl_stable_chk: slot control changes only through its own address.
    ctrl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(slot_ctrl));
endmodule

// File: tb/hp_slot_cmd_tracker_bench.sv
module hp_slot_cmd_tracker_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        hp_capable;
    logic        conform_mode;
    logic        cfg_wr;
    logic [11:0] cfg_addr;
    logic [15:0] cfg_wdata;
    logic [15:0] slot_ctrl;
    logic [15:0] slot_sts;
    logic        cmd_valid;
    logic [5:0]  cmd_data;
    logic        cmd_ack;

    int checks = 0;
    int errors = 0;
    bit done_run = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    hp_slot_cmd_tracker u_hp_slot_cmd_tracker (
        .clk(clk), .rst_n(rst_n), .hp_capable(hp_capable),
        .conform_mode(conform_mode), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .slot_ctrl(slot_ctrl), .slot_sts(slot_sts),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ack(cmd_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // One configuration write; returns at the negedge after the sampling edge.
    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic ack1();
        @(negedge clk);
        cmd_ack = 1'b1;
        @(negedge clk);
        cmd_ack = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 slot_ctrl", 32'(slot_ctrl), 32'h0);
        chk("R1 slot_sts", 32'(slot_sts), 32'h0);
        chk("R1 cmd_valid", 32'(cmd_valid), 32'h0);
    endtask

    task automatic t_enable_only();
        conform_mode = 1'b0;
        wr(12'hA8, 16'h1038);
        chk("R2 stored", 32'(slot_ctrl), 32'h1038);
        chk("R4 no cmd", 32'(cmd_valid), 32'h0);
        idle(3);
        chk("R4 no completion", 32'(slot_sts[4]), 32'h0);
        wr(12'h010, 16'hFFFF);
        chk("R2 other addr", 32'(slot_ctrl), 32'h1038);
        chk("R2 other addr no cmd", 32'(cmd_valid), 32'h0);
    endtask

    task automatic t_change_deliver();
        wr(12'hA8, 16'h1078);
        chk("R3 cmd raised", 32'(cmd_valid), 32'h1);
        chk("R7 data", 32'(cmd_data), 32'h01);
        idle(3);
        chk("R7 held valid", 32'(cmd_valid), 32'h1);
        chk("R7 held data", 32'(cmd_data), 32'h01);
        chk("R8 not early", 32'(slot_sts[4]), 32'h0);
        ack1();
        chk("R8 set after ack", 32'(slot_sts), 32'h0010);
        chk("R7 valid drops", 32'(cmd_valid), 32'h0);
    endtask

    task automatic t_clear();
        wr(12'hAA, 16'h0000);
        chk("R9 zero write keeps", 32'(slot_sts[4]), 32'h1);
        wr(12'hAA, 16'hFFEF);
        chk("R9 other bits ignored", 32'(slot_sts[4]), 32'h1);
        wr(12'hAA, 16'h0010);
        chk("R9 cleared", 32'(slot_sts[4]), 32'h0);
    endtask

    task automatic t_set_wins();
        wr(12'hA8, 16'h0140);
        chk("R7 data 5", 32'(cmd_data), 32'h05);
        @(negedge clk);
        cmd_ack = 1'b1; cfg_wr = 1'b1; cfg_addr = 12'hAA; cfg_wdata = 16'h0010;
        @(negedge clk);
        cmd_ack = 1'b0; cfg_wr = 1'b0;
        chk("R10 set wins", 32'(slot_sts[4]), 32'h1);
        wr(12'hAA, 16'h0010);
    endtask

    task automatic t_conform();
        conform_mode = 1'b1;
        wr(12'hA8, 16'h0140);
        chk("R5 repeat is cmd", 32'(cmd_valid), 32'h1);
        chk("R5 data", 32'(cmd_data), 32'h05);
        ack1();
        chk("R5 completes", 32'(slot_sts[4]), 32'h1);
        wr(12'hAA, 16'h0010);
    endtask

    task automatic t_incapable();
        hp_capable = 1'b0;
        wr(12'hA8, 16'h0FC0);
        chk("R6 stored", 32'(slot_ctrl), 32'h0FC0);
        chk("R6 no cmd conform", 32'(cmd_valid), 32'h0);
        conform_mode = 1'b0;
        wr(12'hA8, 16'h0FC0 ^ 16'h0040);
        chk("R6 no cmd change", 32'(cmd_valid), 32'h0);
        wr(12'hA8, 16'h0FC0);
        hp_capable = 1'b1;
    endtask

    task automatic t_latest_compare();
        wr(12'hA8, 16'h0000);
        chk("R12 first cmd", 32'(cmd_data), 32'h00);
        wr(12'hA8, 16'h0000);
        ack1();
        chk("R12 repeat not held", 32'(cmd_valid), 32'h0);
        wr(12'hAA, 16'h0010);
    endtask

    task automatic t_pending();
        wr(12'hA8, 16'h0040);
        wr(12'hA8, 16'h0080);
        wr(12'hA8, 16'h00C0);
        chk("R11 first still shown", 32'(cmd_data), 32'h01);
        ack1();
        chk("R11 held valid", 32'(cmd_valid), 32'h1);
        chk("R11 latest held", 32'(cmd_data), 32'h03);
        ack1();
        chk("R11 drains", 32'(cmd_valid), 32'h0);
        chk("R8 completed", 32'(slot_sts[4]), 32'h1);
    endtask

    initial begin
        rst_n = 1'b0; hp_capable = 1'b1; conform_mode = 1'b0;
        cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0; cmd_ack = 1'b0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_only();
        t_change_deliver();
        t_clear();
        t_set_wins();
        t_conform();
        t_incapable();
        t_latest_compare();
        t_pending();
        done_run = 1'b1;
    end

    initial begin
        fork
            wait (done_run);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule